// File: doc/BRIEF.md
# Floating-Point Category Mask Unit

This unit takes a 512-bit vector of IEEE-754 numbers and tests every element against a group of number categories. An 8-bit select word chooses the group. Each element gives one bit of a 64-bit mask: the bit is 1 when the element belongs to at least one of the chosen categories. The elements can be single precision (sixteen lanes) or double precision (eight lanes).

A scalar control limits the test to element 0, so the mask holds at most one meaningful bit. An optional write-mask enable ANDs the result with a second 64-bit mask. Mask bits above the last element tested are always 0.

The result is registered. It appears together with a valid strobe one clock after the request.

Top module: `fpcls_mask_unit`

## Requirements
- R1: The select word maps one category to each bit: bit 0 quiet NaN, bit 1 positive zero, bit 2 negative zero, bit 3 positive infinity, bit 4 negative infinity, bit 5 denormal, bit 6 negative finite, bit 7 signalling NaN.
- R2: An element's mask bit is the OR, over every category whose select bit is 1, of the element's membership in that category. A select word of 0 gives a mask of 0.
- R3: A denormal has a zero exponent field and a nonzero fraction, with either sign. Negative finite covers negative normals and negative denormals. It excludes negative zero, negative infinity and every NaN.
- R4: A NaN (all-ones exponent, nonzero fraction) is quiet when the top fraction bit is 1 and signalling when it is 0. Either sign can be quiet or signalling.
- R5: With prec_dbl=0 and scalar_mode=0, mask bit i (i = 0..15) classifies vec_in[32i+31:32i] as a single-precision value (sign at bit 31, 8-bit exponent, 23-bit fraction). Bits 63:16 are 0.
- R6: With prec_dbl=1 and scalar_mode=0, mask bit i (i = 0..7) classifies vec_in[64i+63:64i] as a double-precision value (sign at bit 63, 11-bit exponent, 52-bit fraction). Bits 63:8 are 0.
- R7: With scalar_mode=1, only element 0 is classified, in the selected precision. Mask bits 63:1 are 0.
- R8: With wmask_en=1, the mask is ANDed bit by bit with wmask_in. With wmask_en=0, wmask_in has no effect.
- R9: out_valid is 1 exactly one cycle after a cycle with req_valid=1. mask_out is loaded only in that cycle and holds its value while req_valid is 0.
- R10: While rst_n is low, out_valid and mask_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; the inputs are sampled in this cycle |
| vec_in | input | 512 | Packed source elements, element 0 in the low bits |
| cat_sel | input | 8 | Category select word |
| prec_dbl | input | 1 | 1 = double-precision elements, 0 = single-precision elements |
| scalar_mode | input | 1 | 1 = test element 0 only |
| wmask_en | input | 1 | 1 = AND the result with wmask_in |
| wmask_in | input | 64 | Second mask used for write masking |
| out_valid | output | 1 | Result strobe, one cycle after req_valid |
| mask_out | output | 64 | Registered category mask |

## Verification
A wrong category decode, such as a quiet/signalling swap or a negative zero counted as negative finite, flips a mask bit. That bit is visible on the result that follows the very request that carried the affected value under the matching select bit. The bench applies every select word against tables of boundary values in each mode and rotates the tables across lanes. A lane-wiring or field-position fault therefore shows up within a few requests. Faults in zero extension, the scalar cut or write masking show up in the upper or cleared bits of the same result. A wrong strobe or a result that fails to hold shows up one cycle after the request.

// File: rtl/fpcls_pkg.sv
package fpcls_pkg;
   localparam int CAT_N       = 8;
   localparam int CAT_QNAN    = 0;
   localparam int CAT_PZERO   = 1;
   localparam int CAT_NZERO   = 2;
   localparam int CAT_PINF    = 3;
   localparam int CAT_NINF    = 4;
   localparam int CAT_DENORM  = 5;
   localparam int CAT_NEGFIN  = 6;
   localparam int CAT_SNAN    = 7;

   typedef logic [CAT_N-1:0] cat_t;

   localparam int SGL_EXP_W  = 8;
   localparam int SGL_FRAC_W = 23;
   localparam int DBL_EXP_W  = 11;
   localparam int DBL_FRAC_W = 52;
endpackage

// File: rtl/fpcls_elem.sv
module fpcls_elem
   import fpcls_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int ELEM_W = EXP_W + FRAC_W + 1
) (
   input  logic [ELEM_W-1:0] elem,
   output cat_t              cats
);
   logic              sgn;
   logic [EXP_W-1:0]  expf;
   logic [FRAC_W-1:0] frac;
   logic              exp_max, exp_min, frac_nz;

   assign sgn     = elem[ELEM_W-1];
   assign expf    = elem[ELEM_W-2:FRAC_W];
   assign frac    = elem[FRAC_W-1:0];
   assign exp_max = &expf;
   assign exp_min = ~|expf;
   assign frac_nz = |frac;

   always_comb begin
      cats              = '0;
      cats[CAT_QNAN]    = exp_max &  frac[FRAC_W-1];
      cats[CAT_SNAN]    = exp_max & ~frac[FRAC_W-1] & frac_nz;
      cats[CAT_PINF]    = exp_max & ~frac_nz & ~sgn;
      cats[CAT_NINF]    = exp_max & ~frac_nz &  sgn;
      cats[CAT_PZERO]   = exp_min & ~frac_nz & ~sgn;
      cats[CAT_NZERO]   = exp_min & ~frac_nz &  sgn;
      cats[CAT_DENORM]  = exp_min &  frac_nz;
      cats[CAT_NEGFIN]  = sgn & ~exp_max & (frac_nz | ~exp_min);
   end
endmodule

// File: rtl/fpcls_vec.sv
module fpcls_vec
   import fpcls_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int LANES  = 16,
   localparam int ELEM_W = EXP_W + FRAC_W + 1,
   localparam int VEC_W  = ELEM_W * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_en,
   input  logic [VEC_W-1:0] vec,
   input  cat_t             sel,
   output logic [LANES-1:0] hits
);
   if (LANES < 1) begin : g_bad_lanes
      $error("fpcls_vec: LANES must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      cat_t cats;
      fpcls_elem #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_elem (
         .elem (vec[i*ELEM_W +: ELEM_W]),
         .cats (cats)
      );
      assign hits[i] = |(cats & sel);

      // R1 / R4: every category except denormal is exclusive of the others
      // in the same lane, apart from negative finite with denormal.
      a_r1_exclusive_cats: assert property (@(posedge clk) disable iff (!rst_n)
         chk_en |-> $onehot0({cats[CAT_QNAN], cats[CAT_SNAN], cats[CAT_PZERO],
                              cats[CAT_NZERO], cats[CAT_PINF], cats[CAT_NINF],
                              cats[CAT_NEGFIN]}));
      // R3: a denormal has no zero, infinity or NaN membership
      a_r3_denorm_finite: assert property (@(posedge clk) disable iff (!rst_n)
         (chk_en && cats[CAT_DENORM]) |->
            !(cats[CAT_QNAN] || cats[CAT_SNAN] || cats[CAT_PZERO] ||
              cats[CAT_NZERO] || cats[CAT_PINF] || cats[CAT_NINF]));
   end
endmodule

// File: rtl/fpcls_mask_unit.sv
module fpcls_mask_unit
   import fpcls_pkg::*;
#(
   parameter int VEC_W     = 512,
   parameter int MASK_W    = 64,
   parameter bit HAS_WMASK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VEC_W-1:0]  vec_in,
   input  logic [7:0]        cat_sel,
   input  logic              prec_dbl,
   input  logic              scalar_mode,
   input  logic              wmask_en,
   input  logic [MASK_W-1:0] wmask_in,
   output logic              out_valid,
   output logic [MASK_W-1:0] mask_out
);
   localparam int S_ELEM_W = SGL_EXP_W + SGL_FRAC_W + 1;
   localparam int D_ELEM_W = DBL_EXP_W + DBL_FRAC_W + 1;
   localparam int S_LANES  = VEC_W / S_ELEM_W;
   localparam int D_LANES  = VEC_W / D_ELEM_W;

   if (VEC_W % D_ELEM_W != 0 || VEC_W < D_ELEM_W) begin : g_bad_vec
      $error("fpcls_mask_unit: VEC_W must be a nonzero multiple of 64");
   end
   if (MASK_W < S_LANES) begin : g_bad_mask
      $error("fpcls_mask_unit: MASK_W must cover every single-precision lane");
   end

   logic [S_LANES-1:0] s_hits;
   logic [D_LANES-1:0] d_hits;
   logic [MASK_W-1:0]  lane_mask;
   logic [MASK_W-1:0]  next_mask;

   fpcls_vec #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W), .LANES(S_LANES)) u_sgl (
      .clk    (clk),
      .rst_n  (rst_n),
      .chk_en (req_valid),
      .vec    (vec_in),
      .sel    (cat_sel),
      .hits   (s_hits)
   );

   fpcls_vec #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W), .LANES(D_LANES)) u_dbl (
      .clk    (clk),
      .rst_n  (rst_n),
      .chk_en (req_valid),
      .vec    (vec_in),
      .sel    (cat_sel),
      .hits   (d_hits)
   );

   always_comb begin
      lane_mask = '0;
      if (prec_dbl) lane_mask[D_LANES-1:0] = d_hits;
      else          lane_mask[S_LANES-1:0] = s_hits;
      if (scalar_mode) lane_mask[MASK_W-1:1] = '0;
   end

   if (HAS_WMASK) begin : g_wmask
      assign next_mask = wmask_en ? (lane_mask & wmask_in) : lane_mask;
   end else begin : g_no_wmask
      logic unused_wm;
      assign unused_wm = wmask_en ^ (^wmask_in);
      assign next_mask = lane_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         mask_out  <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) mask_out <= next_mask;
      end
   end

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && $past(rst_n)) |=> $stable(mask_out));
   a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (mask_out[MASK_W-1:S_LANES] == '0));
   a_r6_dbl_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prec_dbl) |=> (mask_out[MASK_W-1:D_LANES] == '0));
   a_r7_scalar_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && scalar_mode) |=> (mask_out[MASK_W-1:1] == '0));
   a_r2_empty_select: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cat_sel == 8'h00) |=> (mask_out == '0));
   a_r8_wmask_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && wmask_en && HAS_WMASK) |=> ((mask_out & ~$past(wmask_in)) == '0));
endmodule

// File: tb/fpcls_mask_unit_test.sv
`timescale 1ns/1ps
module fpcls_mask_unit_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         req_valid;
   logic [511:0] vec_in;
   logic [7:0]   cat_sel;
   logic         prec_dbl, scalar_mode, wmask_en;
   logic [63:0]  wmask_in;
   logic         out_valid;
   logic [63:0]  mask_out;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   always #2 clk = ~clk;

   fpcls_mask_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vec_in(vec_in),
      .cat_sel(cat_sel), .prec_dbl(prec_dbl), .scalar_mode(scalar_mode),
      .wmask_en(wmask_en), .wmask_in(wmask_in),
      .out_valid(out_valid), .mask_out(mask_out)
   );

   function automatic logic [31:0] sgl_val(int k);
      case (k % 16)
         0: return 32'h0000_0000;  1: return 32'h8000_0000;
         2: return 32'h7f80_0000;  3: return 32'hff80_0000;
         4: return 32'h7fc0_0000;  5: return 32'hffc0_0001;
         6: return 32'h7f80_0001;  7: return 32'hffa0_0000;
         8: return 32'h0000_0001;  9: return 32'h807f_ffff;
         10: return 32'h3f80_0000; 11: return 32'hbf80_0000;
         12: return 32'h7f7f_ffff; 13: return 32'hff7f_ffff;
         14: return 32'h0040_0000; default: return 32'hc000_0000;
      endcase
   endfunction

   function automatic logic [63:0] dbl_val(int k);
      case (k % 16)
         0: return 64'h0000_0000_0000_0000;  1: return 64'h8000_0000_0000_0000;
         2: return 64'h7ff0_0000_0000_0000;  3: return 64'hfff0_0000_0000_0000;
         4: return 64'h7ff8_0000_0000_0000;  5: return 64'h7ff0_0000_0000_0001;
         6: return 64'hfff4_0000_0000_0000;  7: return 64'h0000_0000_0000_0001;
         8: return 64'h800f_ffff_ffff_ffff;  9: return 64'h3ff0_0000_0000_0000;
         10: return 64'hbff0_0000_0000_0000; 11: return 64'hffef_ffff_ffff_ffff;
         12: return 64'hfff8_0000_0000_0001; 13: return 64'h0008_0000_0000_0000;
         14: return 64'h7fef_ffff_ffff_ffff; default: return 64'hc000_0000_0000_0000;
      endcase
   endfunction

   // Reference category word from the field layout in R1, R3, R4.
   function automatic logic [7:0] ref_cats(logic s, int unsigned e, int unsigned emax,
                                           logic topf, logic fnz);
      logic [7:0] c = 8'h00;
      if (e == emax) begin
         if (!fnz)      c = s ? 8'h10 : 8'h08;
         else if (topf) c = 8'h01;
         else           c = 8'h80;
      end else if (e == 0 && !fnz) begin
         c = s ? 8'h04 : 8'h02;
      end else begin
         if (e == 0) c[5] = 1'b1;
         if (s)      c[6] = 1'b1;
      end
      return c;
   endfunction

   function automatic logic [7:0] cats_sgl(logic [31:0] v);
      return ref_cats(v[31], int'(v[30:23]), 255, v[22], v[22:0] != 0);
   endfunction

   function automatic logic [7:0] cats_dbl(logic [63:0] v);
      return ref_cats(v[63], int'(v[62:52]), 2047, v[51], v[51:0] != 0);
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one request, then sample at the following falling edge.
   task automatic run_req(logic [511:0] v, logic [7:0] sel, logic dbl, logic scl,
                          logic wen, logic [63:0] wm);
      @(negedge clk);
      req_valid = 1'b1; vec_in = v; cat_sel = sel; prec_dbl = dbl;
      scalar_mode = scl; wmask_en = wen; wmask_in = wm;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
         end
      end
   end

   initial begin
      logic [511:0] v;
      logic [63:0]  exp, wm, held;
      rst_n = 1'b0; req_valid = 1'b1; vec_in = '1; cat_sel = 8'hff;
      prec_dbl = 1'b0; scalar_mode = 1'b0; wmask_en = 1'b0; wmask_in = '1;
      repeat (3) @(negedge clk);
      check("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
      check("R10 reset mask_out", mask_out, 64'd0);
      req_valid = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      // Sweep: every select word in all four precision/scalar modes.
      for (int sel = 0; sel < 256; sel++) begin
         for (int mode = 0; mode < 4; mode++) begin
            int  rot = (sel + 5 * mode) % 16;
            bit  dbl = mode[0];
            bit  scl = mode[1];
            bit  wen = (sel % 3) == 0;
            string tag;
            wm  = {8{sel[7:0] ^ 8'h5a}} ^ {32'h0, 32'(sel * 7)};
            exp = '0;
            v   = '0;
            if (!dbl) begin
               for (int i = 0; i < 16; i++) begin
                  v[32*i +: 32] = sgl_val(i + rot);
                  exp[i] = |(cats_sgl(sgl_val(i + rot)) & 8'(sel));
               end
            end else begin
               for (int i = 0; i < 8; i++) begin
                  v[64*i +: 64] = dbl_val(i + rot);
                  exp[i] = |(cats_dbl(dbl_val(i + rot)) & 8'(sel));
               end
            end
            if (scl) exp[63:1] = '0;
            if (wen) exp = exp & wm;
            tag = scl ? "R7 R1 R2 R3 R4 R8 scalar" :
                  (dbl ? "R6 R1 R2 R3 R4 R8 packed-dbl" : "R5 R1 R2 R3 R4 R8 packed-sgl");
            run_req(v, 8'(sel), dbl, scl, wen, wm);
            check(tag, mask_out, exp);
            check("R9 out_valid after request", {63'd0, out_valid}, 64'd1);
         end
      end

      // R8: with the enable low, an all-zero wmask_in changes nothing.
      v = '0;
      for (int i = 0; i < 16; i++) v[32*i +: 32] = sgl_val(i);
      exp = '0;
      for (int i = 0; i < 16; i++) exp[i] = |(cats_sgl(sgl_val(i)) & 8'hff);
      run_req(v, 8'hff, 1'b0, 1'b0, 1'b0, 64'h0);
      check("R8 wmask ignored when disabled", mask_out, exp);

      // R9: the result holds while req_valid is low, even as the inputs change.
      held = mask_out;
      @(negedge clk);
      vec_in = '0; cat_sel = 8'h02; prec_dbl = 1'b1; wmask_in = '0;
      @(negedge clk);
      check("R9 out_valid low when idle", {63'd0, out_valid}, 64'd0);
      check("R9 mask held when idle", mask_out, held);

      // R2: an empty select gives zero for every special value.
      run_req(v, 8'h00, 1'b0, 1'b0, 1'b0, 64'h0);
      check("R2 empty select", mask_out, 64'd0);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule